// File: doc/BRIEF.md
# Self-Recovering Triplicated Register

This block keeps one register value in three redundant copies, one per redundancy domain. Each domain has its own data input and its own load enable. A clock edge always writes every copy. A domain whose enable is high takes its own new input. A domain whose enable is low takes the bitwise two-of-three majority of the three stored copies, which refreshes it. As a result, a copy that differs from the other two is pulled back into agreement at the next edge where its enable is low.

Each domain has its own voter, so a fault in one voter cannot corrupt the next state of the other two domains. A separate voter drives the voted output port. The block also has a registered per-bit disagreement flag. It is meant to replace a plain register in logic that must survive single state upsets, such as the state register of a control machine. There are two limits. Two copies that agree on a wrong value outvote the correct copy. Once they have overwritten it, nothing is flagged.

Top module: `tmr_selfheal_reg`

## Requirements
- R1: After a clock edge with `rst` high, all three copies, the voted output and the disagreement flag are zero.
- R2: The voted output is the bitwise majority of the three copies. For the copy bits (copy0, copy1, copy2) taken in the order 000 through 111, the result is 0,0,0,1,0,1,1,1.
- R3: At an edge where a domain's enable is high, that domain's copy loads that domain's data input.
- R4: At an edge where a domain's enable is low, that domain's copy loads the majority of the three copies as they stood before the edge.
- R5: When all three enables are high with the same data, all copies and the voted output equal that data after the edge.
- R6: While exactly one copy differs from the other two, the voted output equals the value the other two hold.
- R7: A single divergent copy is repaired after one edge at which its enable is low.
- R8: The disagreement flag has one bit per data bit. A bit is 1 when any two copies differ in that bit. It is registered, so it reflects the copies as they stood one edge earlier.
- R9: If two copies hold the same wrong value, the voted output takes that value. After one edge with all enables low, all copies hold it and the flag returns to zero.
- R10: `rst` takes priority over every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all domains |
| rst | input | 1 | Synchronous active-high reset |
| d0 | input | W | Domain 0 data input |
| d1 | input | W | Domain 1 data input |
| d2 | input | W | Domain 2 data input |
| en0 | input | 1 | Domain 0 load enable |
| en1 | input | 1 | Domain 1 load enable |
| en2 | input | 1 | Domain 2 load enable |
| q0 | output | W | Domain 0 stored copy |
| q1 | output | W | Domain 1 stored copy |
| q2 | output | W | Domain 2 stored copy |
| vote_o | output | W | Bitwise majority of the three copies |
| mism_o | output | W | Registered per-bit disagreement flag |

## Verification
A corrupt copy appears directly on its own `q` port in the cycle after the edge that corrupted it. The flag reports it one edge later. If refresh is broken, the divergent value stays on that port past the next edge with enables low, so a repair failure is visible exactly one cycle after the upset would have been fixed. A wrong voter or a wrong recovery path shows up in the sweep over all copy triples. There, each triple is loaded through the enables, and both the voted result and the converged copies are compared with a majority computed by counting ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_COPIES = 3;
  localparam int unsigned TMR_MAJ    = 2;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  import tmr_pkg::*;

  assign y = (a & b) | (a & c) | (b & c);

  // bitwise count check against the majority threshold
  always_comb begin
    if (!$isunknown({a, b, c})) begin
      for (int i = 0; i < W; i++) begin
        AST_MAJ_BIT: assert (y[i] == ((32'(a[i]) + 32'(b[i]) + 32'(c[i])) >= TMR_MAJ)); // R2
      end
    end
  end
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  input  logic [W-1:0] c0,
  input  logic [W-1:0] c1,
  input  logic [W-1:0] c2,
  output logic [W-1:0] q
);
  logic [W-1:0] voted;

  tmr_voter #(.W(W)) vote_i (
    .a(c0), .b(c1), .c(c2), .y(voted)
  );

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
    else         q <= voted;
  end

  AST_LOAD_OWN: assert property (@(posedge clk) disable iff (rst)
    (!rst && en) |=> q == $past(d)); // R3

  AST_REFRESH_VOTE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en) |=> q == $past(voted)); // R4
endmodule

// File: rtl/tmr_diff.sv
module tmr_diff #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= '0;
    else     flag <= (a ^ b) | (b ^ c) | (a ^ c);
  end

  AST_AGREE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rst && a == b && b == c) |=> flag == '0); // R8
endmodule

// File: rtl/tmr_selfheal_reg.sv
module tmr_selfheal_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic [W-1:0] d2,
  input  logic         en0,
  input  logic         en1,
  input  logic         en2,
  output logic [W-1:0] q0,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2,
  output logic [W-1:0] vote_o,
  output logic [W-1:0] mism_o
);
  import tmr_pkg::*;

  logic [W-1:0] din  [TMR_COPIES];
  logic [W-1:0] copy [TMR_COPIES];
  logic         ld   [TMR_COPIES];

  assign din[0] = d0;
  assign din[1] = d1;
  assign din[2] = d2;
  assign ld[0]  = en0;
  assign ld[1]  = en1;
  assign ld[2]  = en2;

  for (genvar g = 0; g < TMR_COPIES; g++) begin : g_dom
    tmr_copy #(.W(W)) copy_i (
      .clk(clk), .rst(rst), .en(ld[g]), .d(din[g]),
      .c0(copy[0]), .c1(copy[1]), .c2(copy[2]),
      .q(copy[g])
    );
  end

  tmr_voter #(.W(W)) out_vote_i (
    .a(copy[0]), .b(copy[1]), .c(copy[2]), .y(vote_o)
  );

  tmr_diff #(.W(W)) diff_i (
    .clk(clk), .rst(rst),
    .a(copy[0]), .b(copy[1]), .c(copy[2]),
    .flag(mism_o)
  );

  assign q0 = copy[0];
  assign q1 = copy[1];
  assign q2 = copy[2];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (q0 == '0 && q1 == '0 && q2 == '0)); // R1

  AST_ALL_HEAL: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en0 && !en1 && !en2) |=> (q0 == q1 && q1 == q2)); // R7

  AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (rst)
    (q1 == q2) |-> vote_o == q1); // R6
endmodule

// File: tb/tmr_selfheal_reg_tb_top.sv
module tmr_selfheal_reg_tb_top;
  localparam int unsigned W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] d0, d1, d2;
  logic         en0, en1, en2;
  logic [W-1:0] q0, q1, q2, vote_o, mism_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_selfheal_reg #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .d0(d0), .d1(d1), .d2(d2),
    .en0(en0), .en1(en1), .en2(en2),
    .q0(q0), .q1(q1), .q2(q2), .vote_o(vote_o), .mism_o(mism_o)
  );

  function automatic logic [W-1:0] majx(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int n;
      n = int'(a[i]) + int'(b[i]) + int'(c[i]);
      r[i] = (n >= 2);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic e0, logic e1, logic e2, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    en0 = e0; en1 = e1; en2 = e2; d0 = a; d1 = b; d2 = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, '0, '0, '0);
    tick(); tick();
    check("R1 q0", q0, '0);
    check("R1 q1", q1, '0);
    check("R1 q2", q2, '0);
    check("R1 vote", vote_o, '0);
    check("R1 mism", mism_o, '0);
    rst = 1'b0;

    // sweep every triple of copy values
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        for (int c = 0; c < (1 << W); c++) begin
          logic [W-1:0] va, vb, vc, m, x;
          va = W'(a); vb = W'(b); vc = W'(c);
          m = majx(va, vb, vc);
          x = (va ^ vb) | (vb ^ vc) | (va ^ vc);
          drive(1, 1, 1, va, vb, vc);
          tick();
          check("R3 q0", q0, va);
          check("R3 q1", q1, vb);
          check("R3 q2", q2, vc);
          check("R2 vote", vote_o, m);
          check("R8 mism lag", mism_o, '0);
          drive(0, 0, 0, '0, '0, '0);
          tick();
          check("R4 q0", q0, m);
          check("R4 q1", q1, m);
          check("R4 q2", q2, m);
          check("R8 mism", mism_o, x);
        end
      end
    end
    tick();

    // R5 common load
    drive(1, 1, 1, 4'h7, 4'h7, 4'h7);
    tick();
    check("R5 q0", q0, 4'h7);
    check("R5 q1", q1, 4'h7);
    check("R5 q2", q2, 4'h7);
    check("R5 vote", vote_o, 4'h7);

    // single upset in copy 0
    drive(1, 1, 1, 4'hA, 4'hA, 4'hA);
    tick();
    drive(1, 0, 0, 4'h5, 4'h0, 4'h0);
    tick();
    check("R3 upset q0", q0, 4'h5);
    check("R6 vote", vote_o, 4'hA);
    drive(0, 0, 0, '0, '0, '0);
    tick();
    check("R7 q0", q0, 4'hA);
    check("R8 mism", mism_o, 4'hF);
    tick();
    check("R8 clear", mism_o, 4'h0);

    // single upset in copy 2
    drive(0, 0, 1, 4'h0, 4'h0, 4'h8);
    tick();
    check("R6 vote c2", vote_o, 4'hA);
    drive(0, 0, 0, '0, '0, '0);
    tick();
    check("R7 q2", q2, 4'hA);
    check("R8 mism c2", mism_o, 4'h2);

    // double agreeing upset
    drive(1, 1, 0, 4'h3, 4'h3, 4'h0);
    tick();
    check("R9 vote", vote_o, 4'h3);
    drive(0, 0, 0, '0, '0, '0);
    tick();
    check("R9 q2", q2, 4'h3);
    check("R9 mism", mism_o, 4'h9);
    tick();
    check("R9 quiet", mism_o, 4'h0);
    check("R9 vote kept", vote_o, 4'h3);

    // reset priority
    rst = 1'b1;
    drive(1, 1, 1, 4'hF, 4'hF, 4'hF);
    tick();
    check("R10 q0", q0, '0);
    check("R10 q1", q1, '0);
    check("R10 q2", q2, '0);
    check("R10 vote", vote_o, '0);
    tick();
    check("R10 mism", mism_o, '0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule